// File: doc/BRIEF.md
# Dual-Map Register Renamer with Retire-Time Flush

This block renames architectural destination registers onto physical registers and tracks every renamed instruction in a circular in-order window until it retires. It holds two translation tables. The speculative table sits beside decode and changes as each rename group is accepted. The committed table sits at the retire end and changes only when an instruction leaves the window. Up to two instructions are renamed per cycle, and up to two retire per cycle. Physical registers come from a bitmap free list. The lowest-numbered free registers are granted first.

Completion reports and kill reports arrive from outside, tagged with the window slot index. A kill does nothing at the moment it arrives. It only sets a flag on the slot. When a flagged slot becomes the oldest entry, the controller moves from state RUN to state FLUSH. That single FLUSH cycle empties the window, copies the committed table over the speculative one, rebuilds the free list from the committed table, and drives a restart address to fetch. The restart address is the PC stored with the flagged entry. The controller then returns to RUN. Exceptions and mispredicted branches both use this path.

The controller has two states. RUN is the normal state, with renaming and retirement. FLUSH is the one-cycle recovery state. RUN goes to FLUSH when the oldest valid entry carries the kill flag. FLUSH always goes back to RUN on the next cycle.

Top module: `rename_retire_unit`

## Requirements
- R1: After reset, the speculative and committed tables map architectural register i to physical register i. Physical registers numbered ARCH_REGS and above are free. The window is empty, `ren_ready` is 1, and `redirect_valid` and `retire_valid` are 0.
- R2: An accepted rename group takes its new physical registers from the two lowest-numbered free registers, and lane 0 gets the lower one. Lane 1 may be valid only when lane 0 is valid. The two lanes never receive the same register.
- R3: Each lane's source register is translated through the speculative table. If lane 1's source equals lane 0's destination, lane 1 instead sees lane 0's new physical register.
- R4: `ren_prev_phys` reports the mapping that each destination replaces. For lane 1 this includes the mapping written by lane 0 when the two destinations are the same.
- R5: `ren_ready` is 0 whenever the window has fewer than two free slots or the free list holds fewer than two registers. The window count never exceeds its depth.
- R6: Retirement follows program order. Up to two of the oldest entries retire in a cycle, each only when it is valid, complete and not killed. `retire_valid[1]` is set only together with `retire_valid[0]`.
- R7: A retiring entry writes its new register into the committed table. It also returns its previous physical register to the free list, where a later rename can receive it.
- R8: A kill report only flags the slot. While the flagged entry is not the oldest, renaming, retirement and `redirect_valid` are unaffected.
- R9: When a flagged entry is the oldest, `ren_ready` drops that cycle. The next cycle is the FLUSH cycle, in which `redirect_valid` is 1 and `redirect_pc` equals the flagged entry's PC. In that cycle no rename is accepted and nothing retires. `redirect_valid` lasts a single cycle, and the window is empty afterwards.
- R10: After FLUSH, the speculative table equals the committed table. The free list holds exactly the physical registers not named in the committed table, and renaming starts again at lowest free first.
- R11: `ren_tag` gives each lane its window slot. Lane 0 takes the tail slot and lane 1 the next one, both modulo the window depth. Slots start from 0 after reset and after FLUSH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 2 | Rename request per lane (bit 0 = lane 0) |
| ren_dst | input | 2x AW | Architectural destination per lane |
| ren_src | input | 2x AW | Architectural source per lane |
| ren_pc | input | 2x PCW | Instruction PC per lane |
| ren_ready | output | 1 | Group can be accepted this cycle |
| ren_src_phys | output | 2x PW | Translated source per lane |
| ren_new_phys | output | 2x PW | Newly granted physical destination per lane |
| ren_prev_phys | output | 2x PW | Replaced mapping per lane |
| ren_tag | output | 2x TW | Window slot per lane |
| cmp_valid | input | 2 | Completion report valid, two ports |
| cmp_tag | input | 2x TW | Slot of each completion report |
| kill_valid | input | 1 | Kill report valid |
| kill_tag | input | TW | Slot to flag as killed |
| retire_valid | output | 2 | Oldest one or two entries retiring this cycle |
| redirect_valid | output | 1 | Restart fetch (FLUSH cycle) |
| redirect_pc | output | PCW | Restart address |

## Verification
Two behaviours can fall into the same cycle: a pending rename group and a killed entry that has reached the head of the window. The bench holds a two-lane rename request asserted through the detection cycle and through the FLUSH cycle. It checks that `ren_ready` stays low in both cycles. It then checks that the first group accepted afterwards receives the lowest registers of the rebuilt free list and sources taken from the restored table. If any register had been consumed during recovery, those values would differ. A second overlap is also checked: retirement of an older entry in the same cycle that a younger entry is flagged. Here the older entry must retire, the killed entry must not, and no redirect may appear before the flagged entry is the oldest.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rr_state_e;
endpackage

// File: rtl/rr_map_tables.sv
module rr_map_tables #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    spec_we,
    input  logic [1:0][AW-1:0]            spec_arch,
    input  logic [1:0][PW-1:0]            spec_phys,
    input  logic [1:0]                    cmt_we,
    input  logic [1:0][AW-1:0]            cmt_arch,
    input  logic [1:0][PW-1:0]            cmt_phys,
    input  logic                          restore,
    output logic [ARCH_REGS-1:0][PW-1:0]  spec_q,
    output logic [ARCH_REGS-1:0][PW-1:0]  cmt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                spec_q[i] <= PW'(i);
                cmt_q[i]  <= PW'(i);
            end
        end else begin
            if (restore) begin
                spec_q <= cmt_q;
            end else begin
                for (int k = 0; k < 2; k++)
                    if (spec_we[k]) spec_q[spec_arch[k]] <= spec_phys[k];
            end
            for (int k = 0; k < 2; k++)
                if (cmt_we[k]) cmt_q[cmt_arch[k]] <= cmt_phys[k];
        end
    end
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    take,
    input  logic [1:0]                    give,
    input  logic [1:0][PW-1:0]            give_phys,
    input  logic                          rebuild,
    input  logic [ARCH_REGS-1:0][PW-1:0]  cmt_map,
    output logic [1:0][PW-1:0]            grant,
    output logic                          two_free
);
    logic [PHYS_REGS-1:0] free_q, take_mask, give_mask, used;
    logic                 found0, found1;

    always_comb begin
        grant  = '0;
        found0 = 1'b0;
        found1 = 1'b0;
        for (int p = 0; p < PHYS_REGS; p++) begin
            if (free_q[p]) begin
                if (!found0) begin
                    grant[0] = PW'(p);
                    found0   = 1'b1;
                end else if (!found1) begin
                    grant[1] = PW'(p);
                    found1   = 1'b1;
                end
            end
        end
        two_free = found1;
    end

    always_comb begin
        take_mask = '0;
        give_mask = '0;
        used      = '0;
        for (int k = 0; k < 2; k++) begin
            if (take[k]) take_mask[grant[k]]     = 1'b1;
            if (give[k]) give_mask[give_phys[k]] = 1'b1;
        end
        for (int a = 0; a < ARCH_REGS; a++)
            used[cmt_map[a]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHYS_REGS; p++)
                free_q[p] <= (p >= ARCH_REGS);
        end else if (rebuild) begin
            free_q <= ~used;
        end else begin
            free_q <= (free_q & ~take_mask) | give_mask;
        end
    end
endmodule

// File: rtl/rr_window.sv
module rr_window #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int PW    = 4,
    parameter int PCW   = 16,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [1:0]            push,
    input  logic [1:0][AW-1:0]    push_dst,
    input  logic [1:0][PW-1:0]    push_new,
    input  logic [1:0][PW-1:0]    push_prev,
    input  logic [1:0][PCW-1:0]   push_pc,
    input  logic [1:0]            done_in,
    input  logic [1:0][TW-1:0]    done_tag,
    input  logic                  kill_in,
    input  logic [TW-1:0]         kill_slot,
    input  logic [1:0]            pop,
    output logic [1:0][TW-1:0]    tail_tag,
    output logic [CW-1:0]         count,
    output logic [1:0]            hd_valid,
    output logic [1:0]            hd_done,
    output logic [1:0]            hd_kill,
    output logic [1:0][AW-1:0]    hd_dst,
    output logic [1:0][PW-1:0]    hd_new,
    output logic [1:0][PW-1:0]    hd_prev,
    output logic [PCW-1:0]        hd_pc
);
    logic [DEPTH-1:0]           e_valid, e_done, e_kill;
    logic [DEPTH-1:0][AW-1:0]   e_dst;
    logic [DEPTH-1:0][PW-1:0]   e_new, e_prev;
    logic [DEPTH-1:0][PCW-1:0]  e_pc;
    logic [TW-1:0]              head, tail;
    logic [1:0][TW-1:0]         hd_idx;

    assign tail_tag[0] = tail;
    assign tail_tag[1] = tail + TW'(1);
    assign hd_idx[0]   = head;
    assign hd_idx[1]   = head + TW'(1);
    assign hd_pc       = e_pc[head];

    for (genvar k = 0; k < 2; k++) begin : g_head
        assign hd_valid[k] = e_valid[hd_idx[k]];
        assign hd_done[k]  = e_done[hd_idx[k]];
        assign hd_kill[k]  = e_kill[hd_idx[k]];
        assign hd_dst[k]   = e_dst[hd_idx[k]];
        assign hd_new[k]   = e_new[hd_idx[k]];
        assign hd_prev[k]  = e_prev[hd_idx[k]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            e_valid <= '0;
            e_done  <= '0;
            e_kill  <= '0;
            head    <= '0;
            tail    <= '0;
            count   <= '0;
        end else begin
            for (int k = 0; k < 2; k++)
                if (done_in[k]) e_done[done_tag[k]] <= 1'b1;
            if (kill_in) e_kill[kill_slot] <= 1'b1;
            for (int k = 0; k < 2; k++)
                if (pop[k]) e_valid[hd_idx[k]] <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                if (push[k]) begin
                    e_valid[tail_tag[k]] <= 1'b1;
                    e_done[tail_tag[k]]  <= 1'b0;
                    e_kill[tail_tag[k]]  <= 1'b0;
                    e_dst[tail_tag[k]]   <= push_dst[k];
                    e_new[tail_tag[k]]   <= push_new[k];
                    e_prev[tail_tag[k]]  <= push_prev[k];
                    e_pc[tail_tag[k]]    <= push_pc[k];
                end
            end
            head  <= head + TW'(pop[0]) + TW'(pop[1]);
            tail  <= tail + TW'(push[0]) + TW'(push[1]);
            count <= count + CW'(push[0]) + CW'(push[1])
                           - CW'(pop[0]) - CW'(pop[1]);
        end
    end
endmodule

// File: rtl/rename_retire_unit.sv
module rename_retire_unit
    import rr_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int WIN_DEPTH = 8,
    parameter int PCW       = 16,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int TW = $clog2(WIN_DEPTH),
    localparam int CW = $clog2(WIN_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ren_valid,
    input  logic [1:0][AW-1:0]   ren_dst,
    input  logic [1:0][AW-1:0]   ren_src,
    input  logic [1:0][PCW-1:0]  ren_pc,
    output logic                 ren_ready,
    output logic [1:0][PW-1:0]   ren_src_phys,
    output logic [1:0][PW-1:0]   ren_new_phys,
    output logic [1:0][PW-1:0]   ren_prev_phys,
    output logic [1:0][TW-1:0]   ren_tag,
    input  logic [1:0]           cmp_valid,
    input  logic [1:0][TW-1:0]   cmp_tag,
    input  logic                 kill_valid,
    input  logic [TW-1:0]        kill_tag,
    output logic [1:0]           retire_valid,
    output logic                 redirect_valid,
    output logic [PCW-1:0]       redirect_pc
);
    rr_state_e                    state_q, state_d;
    logic [ARCH_REGS-1:0][PW-1:0] spec_map, cmt_map;
    logic [1:0][PW-1:0]           grant;
    logic                         two_free, head_killed, flushing;
    logic [1:0]                   accept;
    logic [CW-1:0]                win_count;
    logic [1:0]                   hd_valid, hd_done, hd_kill;
    logic [1:0][AW-1:0]           hd_dst;
    logic [1:0][PW-1:0]           hd_new, hd_prev;
    logic [PCW-1:0]               hd_pc;

    assign head_killed = hd_valid[0] && hd_kill[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            redirect_pc <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && head_killed) redirect_pc <= hd_pc;
        end
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        flushing     = 1'b0;
        ren_ready    = 1'b0;
        retire_valid = 2'b00;
        unique case (state_q)
            ST_RUN: begin
                if (head_killed) state_d = ST_FLUSH;
                ren_ready = !head_killed && two_free
                         && (win_count <= CW'(WIN_DEPTH - 2));
                retire_valid[0] = hd_valid[0] && hd_done[0] && !hd_kill[0];
                retire_valid[1] = retire_valid[0] && hd_valid[1]
                               && hd_done[1] && !hd_kill[1];
            end
            ST_FLUSH: begin
                state_d  = ST_RUN;
                flushing = 1'b1;
            end
        endcase
    end
    assign redirect_valid = flushing;

    assign accept[0] = ren_ready && ren_valid[0];
    assign accept[1] = ren_ready && ren_valid[0] && ren_valid[1];

    // translation with lane-0 forwarding into lane 1
    assign ren_new_phys     = grant;
    assign ren_src_phys[0]  = spec_map[ren_src[0]];
    assign ren_prev_phys[0] = spec_map[ren_dst[0]];
    assign ren_src_phys[1]  = (ren_src[1] == ren_dst[0]) ? grant[0] : spec_map[ren_src[1]];
    assign ren_prev_phys[1] = (ren_dst[1] == ren_dst[0]) ? grant[0] : spec_map[ren_dst[1]];

    rr_map_tables #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_maps (
        .clk(clk), .rst_n(rst_n),
        .spec_we(accept), .spec_arch(ren_dst), .spec_phys(grant),
        .cmt_we(retire_valid), .cmt_arch(hd_dst), .cmt_phys(hd_new),
        .restore(flushing), .spec_q(spec_map), .cmt_q(cmt_map)
    );

    rr_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .take(accept), .give(retire_valid), .give_phys(hd_prev),
        .rebuild(flushing), .cmt_map(cmt_map),
        .grant(grant), .two_free(two_free)
    );

    rr_window #(.DEPTH(WIN_DEPTH), .AW(AW), .PW(PW), .PCW(PCW)) u_win (
        .clk(clk), .rst_n(rst_n), .flush(flushing),
        .push(accept), .push_dst(ren_dst), .push_new(grant),
        .push_prev(ren_prev_phys), .push_pc(ren_pc),
        .done_in(cmp_valid & {2{!flushing}}), .done_tag(cmp_tag),
        .kill_in(kill_valid && !flushing), .kill_slot(kill_tag),
        .pop(retire_valid), .tail_tag(ren_tag), .count(win_count),
        .hd_valid(hd_valid), .hd_done(hd_done), .hd_kill(hd_kill),
        .hd_dst(hd_dst), .hd_new(hd_new), .hd_prev(hd_prev), .hd_pc(hd_pc)
    );
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
    parameter int DEPTH = 8,
    parameter int PW    = 4,
    parameter int CW    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          ren_valid,
    input logic                ren_ready,
    input logic [1:0][PW-1:0]  ren_new_phys,
    input logic [1:0]          retire_valid,
    input logic                redirect_valid,
    input logic [CW-1:0]       win_count
);
    AST_DISTINCT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_ready && ren_valid == 2'b11) |-> ren_new_phys[0] != ren_new_phys[1]); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CW'(DEPTH)); // R5
    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid[1] |-> retire_valid[0]); // R6
    AST_FLUSH_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !ren_ready); // R9
    AST_FLUSH_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> retire_valid == 2'b00); // R9
    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid); // R9
    AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> win_count == '0); // R9
endmodule

bind rename_retire_unit rr_checker #(.DEPTH(WIN_DEPTH), .PW(PW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_new_phys(ren_new_phys), .retire_valid(retire_valid),
    .redirect_valid(redirect_valid), .win_count(win_count)
);

// File: tb/tb_rename_retire_unit.sv
module tb_rename_retire_unit;
    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       ren_valid;
    logic [1:0][2:0]  ren_dst, ren_src;
    logic [1:0][15:0] ren_pc;
    logic             ren_ready;
    logic [1:0][3:0]  ren_src_phys, ren_new_phys, ren_prev_phys;
    logic [1:0][2:0]  ren_tag;
    logic [1:0]       cmp_valid;
    logic [1:0][2:0]  cmp_tag;
    logic             kill_valid;
    logic [2:0]       kill_tag;
    logic [1:0]       retire_valid;
    logic             redirect_valid;
    logic [15:0]      redirect_pc;
    int               checks = 0;
    int               errors = 0;

    always #4 clk = ~clk;

    rename_retire_unit dut (.*);

    typedef struct packed {
        logic [1:0]  v;
        logic [2:0]  d0, s0, d1, s1;
        logic [15:0] pc0, pc1;
        logic [3:0]  es0, es1, en0, en1, ep0, ep1;
        logic [2:0]  et0, et1;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'b11, 3'd1, 3'd2, 3'd1, 3'd1, 16'h0100, 16'h0104, 4'd2,  4'd8,  4'd8,  4'd9,  4'd1, 4'd8, 3'd0, 3'd1},
        '{2'b11, 3'd3, 3'd1, 3'd4, 3'd3, 16'h0108, 16'h010c, 4'd9,  4'd10, 4'd10, 4'd11, 4'd3, 4'd4, 3'd2, 3'd3},
        '{2'b01, 3'd5, 3'd4, 3'd0, 3'd0, 16'h0110, 16'h0000, 4'd11, 4'd0,  4'd12, 4'd0,  4'd5, 4'd0, 3'd4, 3'd0},
        '{2'b11, 3'd6, 3'd0, 3'd7, 3'd6, 16'h0150, 16'h0154, 4'd0,  4'd13, 4'd13, 4'd14, 4'd6, 4'd7, 3'd5, 3'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        ren_valid = '0; cmp_valid = '0; kill_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ren_dst = '0; ren_src = '0; ren_pc = '0;
        cmp_tag = '0; kill_tag = '0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ready", ren_ready, 1);
        chk("R1 redirect", redirect_valid, 0);
        chk("R1 retire", retire_valid, 0);

        // table walk: rename groups from reset, no retirement yet
        for (int i = 0; i < 4; i++) begin
            ren_valid = VECS[i].v;
            ren_dst = {VECS[i].d1, VECS[i].d0};
            ren_src = {VECS[i].s1, VECS[i].s0};
            ren_pc  = {VECS[i].pc1, VECS[i].pc0};
            #1;
            chk("R5 ready", ren_ready, 1);
            chk("R3 src0", ren_src_phys[0], VECS[i].es0);
            chk("R2 new0", ren_new_phys[0], VECS[i].en0);
            chk("R4 prev0", ren_prev_phys[0], VECS[i].ep0);
            chk("R11 tag0", ren_tag[0], VECS[i].et0);
            if (VECS[i].v[1]) begin
                chk("R3 src1 forward", ren_src_phys[1], VECS[i].es1);
                chk("R2 new1", ren_new_phys[1], VECS[i].en1);
                chk("R4 prev1 forward", ren_prev_phys[1], VECS[i].ep1);
                chk("R11 tag1", ren_tag[1], VECS[i].et1);
            end
            next_cycle();
            idle();
        end
        chk("R5 full window stalls", ren_ready, 0);

        // complete slots 0 and 1
        cmp_valid = 2'b11; cmp_tag = {3'd1, 3'd0};
        next_cycle(); idle();
        chk("R6 dual retire", retire_valid, 2'b11);
        next_cycle();
        // freed register 1 is granted again
        ren_valid = 2'b01; ren_dst[0] = 3'd2; ren_src[0] = 3'd1; ren_pc[0] = 16'h0118;
        #1;
        chk("R7 freed reg reused", ren_new_phys[0], 4'd1);
        chk("R7 src after retire", ren_src_phys[0], 4'd9);
        chk("R11 tag wraps order", ren_tag[0], 3'd7);
        next_cycle(); idle();

        // out-of-order completion does not retire
        cmp_valid = 2'b01; cmp_tag[0] = 3'd3;
        next_cycle(); idle();
        chk("R6 head incomplete", retire_valid, 2'b00);
        cmp_valid = 2'b01; cmp_tag[0] = 3'd2;
        next_cycle(); idle();
        chk("R6 in-order pair", retire_valid, 2'b11);
        next_cycle();

        // flag slot 5 while slot 4 is still pending
        kill_valid = 1'b1; kill_tag = 3'd5;
        next_cycle(); idle();
        chk("R8 no redirect", redirect_valid, 0);
        chk("R8 ready unaffected", ren_ready, 1);
        chk("R8 no retire", retire_valid, 0);
        cmp_valid = 2'b01; cmp_tag[0] = 3'd4;
        next_cycle(); idle();
        chk("R6 killed not retired", retire_valid, 2'b01);
        next_cycle();
        // rename held while the killed entry is oldest and through recovery
        ren_valid = 2'b11; ren_dst = {3'd7, 3'd6}; ren_src = {3'd6, 3'd2};
        ren_pc = {16'h0204, 16'h0200};
        #1;
        chk("R9 ready low at detect", ren_ready, 0);
        chk("R9 redirect not yet", redirect_valid, 0);
        next_cycle();
        chk("R9 redirect", redirect_valid, 1);
        chk("R9 redirect pc", redirect_pc, 16'h0150);
        chk("R9 ready low in flush", ren_ready, 0);
        chk("R9 no retire in flush", retire_valid, 0);
        next_cycle();
        chk("R9 redirect single cycle", redirect_valid, 0);
        chk("R10 ready after flush", ren_ready, 1);
        chk("R10 src restored", ren_src_phys[0], 4'd2);
        chk("R10 src1 forward", ren_src_phys[1], 4'd1);
        chk("R10 new0 rebuilt", ren_new_phys[0], 4'd1);
        chk("R10 new1 rebuilt", ren_new_phys[1], 4'd3);
        chk("R10 prev0", ren_prev_phys[0], 4'd6);
        chk("R10 prev1", ren_prev_phys[1], 4'd7);
        chk("R11 tag reset", ren_tag[0], 3'd0);
        chk("R11 tag1 reset", ren_tag[1], 3'd1);
        next_cycle(); idle();
        #1;
        chk("R10 no retire", retire_valid, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule